// File: doc/BRIEF.md
# Primary Clock Failure Guard

This block keeps watch on a primary system clock from an internal reference clock that never stops. It divides the reference clock by 64 to make a slow sample clock. In each sample period it checks whether the primary clock produced a falling edge. If a sample period ends without one, the block treats the primary clock as failed. It then sets a sticky failure flag and drives a source select that moves the system clock onto the internal oscillator.

The failure flag raises the interrupt output only while the interrupt enable is high. The fail-safe state holds until reset, a sleep-entry pulse or a clock-source-select write ends it. A flag-clear strobe has no effect until that state has ended. Detection runs only when the monitor is enabled and the oscillator start-up timer reports done. The glitch-free clock multiplexer and the oscillator analog sit outside this block.

The monitoring latch is built as a toggle handshake. At each rising edge of the sample clock the reference side flips an epoch bit, which clears the latch. On its falling edges the primary side echoes that bit back, which sets the latch. The echoed bit crosses into the reference domain through a two-flop synchronizer, and the latch counts as set when the echo matches the epoch.

Top module: `clk_fail_guard`

## Requirements
- R1: While rst_ni is low, fail_flag_o, irq_o and clk_sel_o are 0, and osc_ok_o equals ost_done_i. All state returns to this value whatever it held before reset.
- R2: A primary clock with a falling edge at least every few reference cycles never causes a failure, across any number of 64-cycle sample periods.
- R3: With the monitor enabled and the start-up timer done, a primary clock that stops is detected within 192 reference cycles: fail_flag_o goes to 1 and clk_sel_o goes to 1.
- R4: irq_o is 1 exactly when fail_flag_o is 1 and irq_en_i is 1. A change of irq_en_i alone moves irq_o without touching the flag.
- R5: In the fail-safe state clk_sel_o is 1 (1 selects the internal oscillator, 0 the primary clock) and osc_ok_o is 0. Outside it, clk_sel_o is 0 and osc_ok_o equals ost_done_i.
- R6: The fail-safe state ends only on reset, a one-cycle sleep_i pulse or a one-cycle sel_wr_i pulse. A primary clock that restarts does not end it.
- R7: A flag_clr_i pulse is ignored while the fail-safe state is active, and the flag stays 1. After the state has ended, a flag_clr_i pulse clears the flag.
- R8: With mon_en_i at 0, a stopped primary clock never enters the fail-safe state and never sets the flag.
- R9: With ost_done_i at 0, no failure is detected. Detection starts after ost_done_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Always-running internal reference clock |
| pri_clk_i | input | 1 | Primary system clock under watch |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_en_i | input | 1 | Monitor enable |
| irq_en_i | input | 1 | Interrupt enable |
| sleep_i | input | 1 | Sleep-entry pulse (reference domain) |
| sel_wr_i | input | 1 | Clock-source-select write strobe |
| flag_clr_i | input | 1 | Failure-flag clear strobe |
| ost_done_i | input | 1 | Oscillator start-up timer expired |
| fail_flag_o | output | 1 | Sticky failure flag |
| irq_o | output | 1 | Failure interrupt |
| clk_sel_o | output | 1 | 1 = internal oscillator, 0 = primary clock |
| osc_ok_o | output | 1 | Running from the primary clock after start-up |

## Verification
A wrong epoch or echo bit shows up as a false failure on a healthy primary clock: clk_sel_o and fail_flag_o rise within one sample period, about 64 reference cycles. A lost arming state shows up in one of two ways. Either a stopped clock is never reported, with clk_sel_o still 0 after 192 cycles, or it is reported while the enable or the start-up timer is low. A wrong fail-safe register shows at once on clk_sel_o and osc_ok_o. It also shows on the first flag-clear or exit strobe, because the flag would then clear or stay set against R6 and R7.

// File: rtl/clk_fail_pkg.sv
package clk_fail_pkg;
  typedef enum logic {
    SRC_PRIMARY  = 1'b0,
    SRC_INTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/cfg_sample_div.sv
module cfg_sample_div #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic samp_rise_o,
  output logic samp_chk_o
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
  end

  // next edge is the sample-clock rise / fall
  assign samp_rise_o = (cnt_q == CW'(DIV - 1));
  assign samp_chk_o  = (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/cfg_activity_sense.sv
module cfg_activity_sense #(
  parameter int SYNC = 2
) (
  input  logic ref_clk_i,
  input  logic pri_clk_i,
  input  logic rst_ni,
  input  logic samp_rise_i,
  output logic seen_o
);
  logic            epoch_q;
  logic [SYNC-1:0] pri_sync_q;
  logic            echo_q;
  logic [SYNC-1:0] ref_sync_q;

  // rising sample edge: flip epoch, which clears the latch
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)          epoch_q <= 1'b0;
    else if (samp_rise_i) epoch_q <= ~epoch_q;
  end

  // primary falling edge: echo epoch, which sets the latch
  always_ff @(negedge pri_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_sync_q <= '0;
      echo_q     <= 1'b0;
    end else begin
      pri_sync_q <= {pri_sync_q[SYNC-2:0], epoch_q};
      echo_q     <= pri_sync_q[SYNC-1];
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_sync_q <= '0;
    else         ref_sync_q <= {ref_sync_q[SYNC-2:0], echo_q};
  end

  assign seen_o = (ref_sync_q[SYNC-1] == epoch_q);
endmodule

// File: rtl/cfg_failover_ctrl.sv
module cfg_failover_ctrl
  import clk_fail_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mon_en_i,
  input  logic     ost_done_i,
  input  logic     samp_rise_i,
  input  logic     samp_chk_i,
  input  logic     seen_i,
  input  logic     sleep_i,
  input  logic     sel_wr_i,
  input  logic     flag_clr_i,
  output logic     flag_o,
  output clk_src_e src_o
);
  logic armed, primed_q, fail_evt, fs_q, flag_q, exit_evt;

  assign armed    = mon_en_i & ost_done_i;
  assign fail_evt = armed & primed_q & samp_chk_i & ~seen_i;
  assign exit_evt = sleep_i | sel_wr_i;

  // require one full sample rise after arming before checking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     primed_q <= 1'b0;
    else if (!armed) primed_q <= 1'b0;
    else if (samp_rise_i) primed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fs_q <= 1'b0;
    else if (exit_evt) fs_q <= 1'b0;
    else if (fail_evt) fs_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (fail_evt)           flag_q <= 1'b1;
    else if (flag_clr_i && !fs_q) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign src_o  = fs_q ? SRC_INTERNAL : SRC_PRIMARY;

  AST_FS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q && !sleep_i && !sel_wr_i |=> fs_q); // R6
  AST_CLR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q && flag_q |=> flag_q); // R7
  AST_OFF_NO_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i && !fs_q |=> !fs_q); // R8
  AST_OST_NO_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ost_done_i && !fs_q |=> !fs_q); // R9
  AST_FS_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_q) |-> flag_q); // R4
endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
  import clk_fail_pkg::*;
#(
  parameter int DIV  = 64,
  parameter int SYNC = 2
) (
  input  logic ref_clk_i,
  input  logic pri_clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic irq_en_i,
  input  logic sleep_i,
  input  logic sel_wr_i,
  input  logic flag_clr_i,
  input  logic ost_done_i,
  output logic fail_flag_o,
  output logic irq_o,
  output logic clk_sel_o,
  output logic osc_ok_o
);
  logic     samp_rise, samp_chk, seen, flag;
  clk_src_e src;

  cfg_sample_div #(.DIV(DIV)) u_div (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .samp_rise_o(samp_rise), .samp_chk_o(samp_chk)
  );

  cfg_activity_sense #(.SYNC(SYNC)) u_sense (
    .ref_clk_i(ref_clk_i), .pri_clk_i(pri_clk_i), .rst_ni(rst_ni),
    .samp_rise_i(samp_rise), .seen_o(seen)
  );

  cfg_failover_ctrl u_ctrl (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .mon_en_i(mon_en_i), .ost_done_i(ost_done_i),
    .samp_rise_i(samp_rise), .samp_chk_i(samp_chk), .seen_i(seen),
    .sleep_i(sleep_i), .sel_wr_i(sel_wr_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag), .src_o(src)
  );

  assign fail_flag_o = flag;
  assign irq_o       = flag & irq_en_i;
  assign clk_sel_o   = (src == SRC_INTERNAL);
  assign osc_ok_o    = ost_done_i & (src == SRC_PRIMARY);

  AST_SEL_NOT_OK: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    clk_sel_o |-> !osc_ok_o); // R5
endmodule

// File: tb/clk_fail_guard_test.sv
module clk_fail_guard_test;
  logic ref_clk = 1'b0, pri_clk = 1'b0, pri_run = 1'b0;
  logic rst_ni = 1'b0, mon_en = 1'b0, irq_en = 1'b0, sleep_p = 1'b0;
  logic sel_wr = 1'b0, flag_clr = 1'b0, ost_done = 1'b0;
  logic fail_flag, irq, clk_sel, osc_ok;
  int total = 0, bad = 0, cyc = 0;

  always #4 ref_clk = ~ref_clk;
  always begin
    #5;
    if (pri_run) pri_clk = ~pri_clk;
  end

  clk_fail_guard uut (
    .ref_clk_i(ref_clk), .pri_clk_i(pri_clk), .rst_ni(rst_ni),
    .mon_en_i(mon_en), .irq_en_i(irq_en), .sleep_i(sleep_p),
    .sel_wr_i(sel_wr), .flag_clr_i(flag_clr), .ost_done_i(ost_done),
    .fail_flag_o(fail_flag), .irq_o(irq), .clk_sel_o(clk_sel), .osc_ok_o(osc_ok)
  );

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {flag, irq, sel, ok}
  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    @(negedge ref_clk);
    act = {fail_flag, irq, clk_sel, osc_ok};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge ref_clk);
  endtask

  // act: 0 none, 1 flag clear, 2 select write, 3 sleep
  task automatic do_act(logic [1:0] a);
    @(posedge ref_clk); #1;
    case (a)
      2'd1: flag_clr = 1'b1;
      2'd2: sel_wr   = 1'b1;
      2'd3: sleep_p  = 1'b1;
      default: ;
    endcase
    @(posedge ref_clk); #1;
    flag_clr = 1'b0; sel_wr = 1'b0; sleep_p = 1'b0;
  endtask

  // {run, irq_en, act[1:0], wait[9:0], exp[3:0]}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 10'd300, 4'b0001}, // R2 healthy
    {1'b0, 1'b0, 2'd0, 10'd300, 4'b1010}, // R3 R5 stop
    {1'b0, 1'b1, 2'd0, 10'd10,  4'b1110}, // R4 irq gate
    {1'b0, 1'b1, 2'd1, 10'd10,  4'b1110}, // R7 clr ignored
    {1'b1, 1'b1, 2'd0, 10'd300, 4'b1110}, // R6 recovery no exit
    {1'b1, 1'b1, 2'd2, 10'd10,  4'b1101}, // R6 select write exit
    {1'b1, 1'b1, 2'd1, 10'd10,  4'b0001}, // R7 clr after exit
    {1'b0, 1'b0, 2'd0, 10'd300, 4'b1010}, // R3 stop again
    {1'b1, 1'b0, 2'd0, 10'd20,  4'b1010}, // R6 restart, still held
    {1'b1, 1'b0, 2'd3, 10'd300, 4'b1001}, // R6 sleep exit
    {1'b1, 1'b0, 2'd1, 10'd10,  4'b0001}, // R7 clear
    {1'b0, 1'b0, 2'd3, 10'd300, 4'b1010}  // R3 refail after sleep
  };

  initial begin
    wait_cyc(3);
    check("R1 reset", 4'b0000);
    @(posedge ref_clk); #1;
    rst_ni = 1'b1; mon_en = 1'b1; ost_done = 1'b1; pri_run = 1'b1;
    wait_cyc(5);

    for (int i = 0; i < NV; i++) begin
      pri_run = VEC[i][17];
      irq_en  = VEC[i][16];
      do_act(VEC[i][15:14]);
      wait_cyc(int'(VEC[i][13:4]));
      check($sformatf("R2-6 vector %0d (R2 R3 R4 R5 R6 R7)", i), VEC[i][3:0]);
    end

    // R8: monitor off, primary stopped
    mon_en = 1'b0;
    do_act(2'd2);
    do_act(2'd1);
    wait_cyc(300);
    check("R8 disabled", 4'b0001);

    // R9: start-up timer not done
    mon_en = 1'b1; ost_done = 1'b0;
    wait_cyc(300);
    check("R9 ost low", 4'b0000);
    ost_done = 1'b1;
    wait_cyc(300);
    check("R9 R3 after ost", 4'b1010);

    // R4: enable change moves irq only
    irq_en = 1'b1;
    wait_cyc(2);
    check("R4 irq on", 4'b1110);
    irq_en = 1'b0;
    wait_cyc(2);
    check("R4 irq off", 4'b1010);

    // R1: reset clears fail-safe
    @(posedge ref_clk); #1;
    rst_ni = 1'b0;
    wait_cyc(2);
    check("R1 reset in fail-safe", 4'b0001);
    @(posedge ref_clk); #1;
    rst_ni = 1'b1; pri_run = 1'b1;
    wait_cyc(400);
    check("R2 after reset", 4'b0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule